// File: doc/BRIEF.md
# Codec power and reset sequencer

This control block sits beside the analog and clocking sections of a mixed-signal audio device. It enforces a timed start-up lockout after a hardware or software reset, holds back the clocks-valid indication while the clock synthesizer settles, and drives the per-block power enables. Four output power stages are tracked: headphone left, headphone right, speaker left and speaker right. Each stage shuts itself off on overcurrent and stays off until software re-arms that stage alone.

Software reaches the block through a paged register port. A write is presented for one cycle as page, register address, data and strobe. Read data follows the page and address combinationally. While the start-up lockout runs, the block drops power-control writes and coefficient-region writes without effect and sets a sticky error flag. A separate strobe passes accepted coefficient-region writes on to the memories, which sit outside this block. All timing is counted in reference-clock cycles, set by parameters.

Top module: `codec_pwr_seq`

## Requirements
- R1: While reset is held, busy_o=1, blk_en_o=0, synth_en_o=0, clk_valid_o=0, touch_en_o=1 and stage_en_o=4'b1111.
- R2: busy_o stays 1 for exactly INIT_CYCLES rising edges after reset release or after a software reset, then stays 0.
- R3: While busy_o=1, writes to page 1 register 2 (block power), page 1 register 5 (synth enable) and page 3 register 4 (touch power-down) change nothing. Each such write sets a sticky error flag, read at status (page 0 register 2) bit 2, that only a reset clears.
- R4: coef_we_o follows we_i for pages COEF_PG_LO..COEF_PG_HI (8..63 by default) only while busy_o=0. A write to those pages while busy is dropped and sets the error flag. coef_we_o is 0 for any other page.
- R5: Once busy_o=0, bits [NBLK-1:0] of page 1 register 2 drive blk_en_o and read back. Writing any register leaves the contents of every other register unchanged. Unmapped addresses read 0.
- R6: Bit 7 of page 3 register 4 powers the touch-detection block down (touch_en_o=0 when 1). It defaults to 0 and reads back.
- R7: Bit 7 of page 1 register 5 drives synth_en_o. clk_valid_o rises SETTLE_CYCLES edges after the enabling write edge and falls at the edge that clears the enable.
- R8: oc_i[k]=1 at a rising edge latches stage k off: stage_en_o[k]=0, and it stays 0 after oc_i[k] falls. Status bits 7:4 show the latched stages, with stage 0 at bit 4. Stage index: 0 headphone left, 1 headphone right, 2 speaker left, 3 speaker right.
- R9: Writing 1 to page 1 register 31 bit 7 re-arms stage 0 and bit 6 re-arms stage 1. Page 1 register 32 bit 7 re-arms stage 2 and bit 6 re-arms stage 3. Only the addressed stage is released, and no other register changes.
- R10: Re-arm bits read back as 1 in the cycle after the write and as 0 from the following cycle.
- R11: If oc_i[k] is 1 in the cycle of a re-arm write for stage k, stage k stays off.
- R12: Writing 1 to page 0 register 1 bit 0 is a software reset. It restores every register, clears the error flag and all latched shutdowns, and restarts the start-up lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| page_i | input | 8 | Register page select |
| addr_i | input | 7 | Register address within page |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | 8 | Read data for page_i/addr_i |
| oc_i | input | 4 | Per-stage overcurrent detect |
| busy_o | output | 1 | Start-up lockout active |
| clk_valid_o | output | 1 | Synthesized clocks settled |
| synth_en_o | output | 1 | Clock synthesizer enable |
| blk_en_o | output | NBLK | Per-block power enables |
| touch_en_o | output | 1 | Touch-detection power enable |
| stage_en_o | output | 4 | Per-stage output enables |
| coef_we_o | output | 1 | Accepted coefficient-region write strobe |

## Verification
Properties checked on every cycle:
- busy_o never returns after it clears unless a software reset occurs, and a software reset always brings it back.
- Block-power writes during lockout leave the enables unchanged.
- coef_we_o never fires while busy.
- clk_valid_o never stands without the synth enable.
- An overcurrent always turns its stage off on the next cycle.
- A stage enable only rises after a re-arm or software-reset write.

The bench's scenarios cover the rest:
- The exact edge counts of both timed windows.
- The register map and its readback.
- Stage isolation on re-arm.
- Self-clearing readback.
- The race between overcurrent and re-arm.
- That the error flag holds after the lockout ends.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int unsigned NSTAGE = 4;

  localparam logic [7:0] PG_CTRL  = 8'd0;
  localparam logic [7:0] PG_PWR   = 8'd1;
  localparam logic [7:0] PG_TOUCH = 8'd3;

  localparam logic [6:0] RA_SWRST   = 7'd1;
  localparam logic [6:0] RA_STATUS  = 7'd2;
  localparam logic [6:0] RA_BLKPWR  = 7'd2;
  localparam logic [6:0] RA_SYNTH   = 7'd5;
  localparam logic [6:0] RA_TOUCH   = 7'd4;
  localparam logic [6:0] RA_HP_RST  = 7'd31;
  localparam logic [6:0] RA_SPK_RST = 7'd32;

  typedef enum logic [1:0] {
    ST_HP_L  = 2'd0,
    ST_HP_R  = 2'd1,
    ST_SPK_L = 2'd2,
    ST_SPK_R = 2'd3
  } stage_e;

  typedef struct packed {
    logic [NSTAGE-1:0] shut;
    logic              rsvd;
    logic              err;
    logic              clk_ok;
    logic              busy;
  } status_t;
endpackage

// File: rtl/cps_countdown.sv
module cps_countdown #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic done_o
);
  localparam int unsigned W = $clog2(CYCLES + 1);
  localparam logic [W-1:0] LOAD = W'(CYCLES);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= LOAD;
    else if (clr_i)          cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/cps_oc_latch.sv
module cps_oc_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic oc_i,
  input  logic rearm_i,
  output logic shut_o
);
  logic shut_q;

  // overcurrent wins over any release in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    shut_q <= 1'b0;
    else if (oc_i)                  shut_q <= 1'b1;
    else if (soft_rst_i || rearm_i) shut_q <= 1'b0;
  end

  assign shut_o = shut_q;
endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
  import cps_pkg::*;
#(
  parameter int unsigned INIT_CYCLES   = 50000,
  parameter int unsigned SETTLE_CYCLES = 500000,
  parameter int unsigned NBLK          = 6,
  parameter logic [7:0]  COEF_PG_LO    = 8'd8,
  parameter logic [7:0]  COEF_PG_HI    = 8'd63
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        page_i,
  input  logic [6:0]        addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              we_i,
  output logic [7:0]        rdata_o,
  input  logic [NSTAGE-1:0] oc_i,
  output logic              busy_o,
  output logic              clk_valid_o,
  output logic              synth_en_o,
  output logic [NBLK-1:0]   blk_en_o,
  output logic              touch_en_o,
  output logic [NSTAGE-1:0] stage_en_o,
  output logic              coef_we_o
);
  logic              soft_rst, in_coef, pwr_wr, refused, accept;
  logic              init_done, settle_done;
  logic [NSTAGE-1:0] rearm, shut, pulse_q;
  logic [NBLK-1:0]   blk_q;
  logic              synth_q, touch_pd_q, err_q;
  status_t           status;

  assign soft_rst = we_i && page_i == PG_CTRL && addr_i == RA_SWRST && wdata_i[0];
  assign in_coef  = page_i >= COEF_PG_LO && page_i <= COEF_PG_HI;
  assign pwr_wr   = we_i && ((page_i == PG_PWR && (addr_i == RA_BLKPWR || addr_i == RA_SYNTH)) ||
                             (page_i == PG_TOUCH && addr_i == RA_TOUCH));
  assign refused  = busy_o && (pwr_wr || (we_i && in_coef));
  assign accept   = we_i && !busy_o;

  assign rearm[ST_HP_L]  = we_i && page_i == PG_PWR && addr_i == RA_HP_RST  && wdata_i[7];
  assign rearm[ST_HP_R]  = we_i && page_i == PG_PWR && addr_i == RA_HP_RST  && wdata_i[6];
  assign rearm[ST_SPK_L] = we_i && page_i == PG_PWR && addr_i == RA_SPK_RST && wdata_i[7];
  assign rearm[ST_SPK_R] = we_i && page_i == PG_PWR && addr_i == RA_SPK_RST && wdata_i[6];

  cps_countdown #(.CYCLES(INIT_CYCLES)) u_init_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (soft_rst),
    .done_o(init_done)
  );

  cps_countdown #(.CYCLES(SETTLE_CYCLES)) u_settle_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (soft_rst || !synth_q),
    .done_o(settle_done)
  );

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    cps_oc_latch u_latch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .soft_rst_i(soft_rst),
      .oc_i      (oc_i[k]),
      .rearm_i   (rearm[k]),
      .shut_o    (shut[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q      <= '0;
      synth_q    <= 1'b0;
      touch_pd_q <= 1'b0;
      err_q      <= 1'b0;
      pulse_q    <= '0;
    end else if (soft_rst) begin
      blk_q      <= '0;
      synth_q    <= 1'b0;
      touch_pd_q <= 1'b0;
      err_q      <= 1'b0;
      pulse_q    <= '0;
    end else begin
      pulse_q <= rearm;
      if (refused) err_q <= 1'b1;
      if (accept && page_i == PG_PWR && addr_i == RA_BLKPWR) blk_q      <= wdata_i[NBLK-1:0];
      if (accept && page_i == PG_PWR && addr_i == RA_SYNTH)  synth_q    <= wdata_i[7];
      if (accept && page_i == PG_TOUCH && addr_i == RA_TOUCH) touch_pd_q <= wdata_i[7];
    end
  end

  assign busy_o      = !init_done;
  assign synth_en_o  = synth_q;
  assign clk_valid_o = synth_q && settle_done;
  assign blk_en_o    = blk_q;
  assign touch_en_o  = !touch_pd_q;
  assign stage_en_o  = ~shut;
  assign coef_we_o   = we_i && in_coef && !busy_o;

  assign status = '{shut: shut, rsvd: 1'b0, err: err_q, clk_ok: clk_valid_o, busy: busy_o};

  always_comb begin
    rdata_o = '0;
    if (page_i == PG_CTRL && addr_i == RA_STATUS)       rdata_o = status;
    else if (page_i == PG_PWR && addr_i == RA_BLKPWR)   rdata_o = 8'(blk_q);
    else if (page_i == PG_PWR && addr_i == RA_SYNTH)    rdata_o = {synth_q, 7'b0};
    else if (page_i == PG_PWR && addr_i == RA_HP_RST)   rdata_o = {pulse_q[ST_HP_L], pulse_q[ST_HP_R], 6'b0};
    else if (page_i == PG_PWR && addr_i == RA_SPK_RST)  rdata_o = {pulse_q[ST_SPK_L], pulse_q[ST_SPK_R], 6'b0};
    else if (page_i == PG_TOUCH && addr_i == RA_TOUCH)  rdata_o = {touch_pd_q, 7'b0};
  end
endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
  parameter int unsigned NBLK       = 6,
  parameter logic [7:0]  COEF_PG_LO = 8'd8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [7:0]      page_i,
  input logic [6:0]      addr_i,
  input logic            wdata0_i,
  input logic            we_i,
  input logic [3:0]      oc_i,
  input logic            busy_o,
  input logic            clk_valid_o,
  input logic            synth_en_o,
  input logic [NBLK-1:0] blk_en_o,
  input logic [3:0]      stage_en_o,
  input logic            coef_we_o
);
  logic sw_wr;
  assign sw_wr = we_i && page_i == 8'd0 && addr_i == 7'd1 && wdata0_i;

  p_busy_stays_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !sw_wr) |=> !busy_o);

  p_swrst_relocks_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_wr |=> busy_o);

  p_locked_power_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && we_i && page_i == 8'd1 && addr_i == 7'd2) |=> $stable(blk_en_o));

  p_coef_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_we_o |-> (we_i && !busy_o && page_i >= COEF_PG_LO));

  p_clk_needs_synth_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_valid_o |-> synth_en_o);

  p_oc_trips_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|oc_i) |=> ((stage_en_o & $past(oc_i)) == 4'b0));

  p_stage_rise_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(stage_en_o & ~$past(stage_en_o))) |->
      $past(we_i && ((page_i == 8'd1 && (addr_i == 7'd31 || addr_i == 7'd32)) ||
                     (page_i == 8'd0 && addr_i == 7'd1))));
endmodule

bind codec_pwr_seq cps_checker #(.NBLK(NBLK), .COEF_PG_LO(COEF_PG_LO)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .page_i     (page_i),
  .addr_i     (addr_i),
  .wdata0_i   (wdata_i[0]),
  .we_i       (we_i),
  .oc_i       (oc_i),
  .busy_o     (busy_o),
  .clk_valid_o(clk_valid_o),
  .synth_en_o (synth_en_o),
  .blk_en_o   (blk_en_o),
  .stage_en_o (stage_en_o),
  .coef_we_o  (coef_we_o)
);

// File: tb/test_codec_pwr_seq.sv
module test_codec_pwr_seq;
  localparam int unsigned INIT   = 20;
  localparam int unsigned SETTLE = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] page = '0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic [3:0] oc = '0;
  logic [7:0] rdata;
  logic       busy, clk_valid, synth_en, touch_en, coef_we;
  logic [5:0] blk_en;
  logic [3:0] stage_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  codec_pwr_seq #(.INIT_CYCLES(INIT), .SETTLE_CYCLES(SETTLE), .NBLK(6)) i_codec_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .page_i(page), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .rdata_o(rdata), .oc_i(oc), .busy_o(busy), .clk_valid_o(clk_valid),
    .synth_en_o(synth_en), .blk_en_o(blk_en), .touch_en_o(touch_en),
    .stage_en_o(stage_en), .coef_we_o(coef_we)
  );

  typedef struct packed {
    logic [7:0] pg;  logic [6:0] ad;  logic [7:0] wd;
    logic [7:0] rpg; logic [6:0] rad; logic [7:0] exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{8'd1, 7'd2,  8'h15, 8'd1, 7'd2,  8'h15},  // R5
    '{8'd3, 7'd4,  8'h80, 8'd3, 7'd4,  8'h80},  // R6
    '{8'd1, 7'd5,  8'h80, 8'd1, 7'd5,  8'h80},  // R7
    '{8'd1, 7'd2,  8'h00, 8'd1, 7'd5,  8'h80},  // R5 retention
    '{8'd3, 7'd4,  8'h00, 8'd1, 7'd2,  8'h00},  // R6
    '{8'd1, 7'd9,  8'hFF, 8'd1, 7'd9,  8'h00},  // R5 unmapped
    '{8'd1, 7'd2,  8'h3F, 8'd3, 7'd4,  8'h00},  // R5
    '{8'd1, 7'd5,  8'h00, 8'd1, 7'd5,  8'h00}   // R7
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] p, input logic [6:0] a, input logic [7:0] d);
    page = p; addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] p, input logic [6:0] a, input logic [7:0] exp, input string tag);
    page = p; addr = a;
    #1;
    chk(rdata, exp, tag);
  endtask

  task automatic oc_pulse(input logic [3:0] m);
    oc = m;
    @(negedge clk);
    oc = '0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    fails++; checks++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({7'b0, busy}, 8'h01, "R1 busy");
    chk({2'b0, blk_en}, 8'h00, "R1 blk_en");
    chk({6'b0, synth_en, clk_valid}, 8'h00, "R1 synth/clk");
    chk({7'b0, touch_en}, 8'h01, "R1 touch_en");
    chk({4'b0, stage_en}, 8'h0F, "R1 stage_en");
    rst_n = 1'b1;

    // R2 lockout length
    repeat (INIT - 1) @(negedge clk);
    chk({7'b0, busy}, 8'h01, "R2 busy before end");
    @(negedge clk);
    chk({7'b0, busy}, 8'h00, "R2 busy cleared");

    // R5 R6 R7 table
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i].pg, VEC[i].ad, VEC[i].wd);
      rd_chk(VEC[i].rpg, VEC[i].rad, VEC[i].exp, "R5/R6/R7 table");
    end
    chk({2'b0, blk_en}, 8'h3F, "R5 blk_en");

    // R6 touch enable
    wr(8'd3, 7'd4, 8'h80);
    chk({7'b0, touch_en}, 8'h00, "R6 touch off");
    wr(8'd3, 7'd4, 8'h00);
    chk({7'b0, touch_en}, 8'h01, "R6 touch on");

    // R7 settle window
    wr(8'd1, 7'd5, 8'h80);
    chk({6'b0, synth_en, clk_valid}, 8'h02, "R7 synth on, not valid");
    repeat (SETTLE - 1) @(negedge clk);
    chk({7'b0, clk_valid}, 8'h00, "R7 not yet valid");
    @(negedge clk);
    chk({7'b0, clk_valid}, 8'h01, "R7 valid");
    rd_chk(8'd0, 7'd2, 8'h02, "R7 status clk bit");
    wr(8'd1, 7'd5, 8'h00);
    chk({6'b0, synth_en, clk_valid}, 8'h00, "R7 disable");

    // R4 coefficient gating after lockout
    page = 8'd8; we = 1'b1; #1;
    chk({7'b0, coef_we}, 8'h01, "R4 coef page 8");
    page = 8'd63; #1;
    chk({7'b0, coef_we}, 8'h01, "R4 coef page 63");
    page = 8'd7; #1;
    chk({7'b0, coef_we}, 8'h00, "R4 page 7");
    page = 8'd64; #1;
    chk({7'b0, coef_we}, 8'h00, "R4 page 64");
    @(negedge clk); we = 1'b0;

    // R8 latch
    wr(8'd1, 7'd2, 8'h2A);
    oc_pulse(4'b0010);
    chk({4'b0, stage_en}, 8'h0D, "R8 stage1 off");
    @(negedge clk);
    chk({4'b0, stage_en}, 8'h0D, "R8 stays off");
    rd_chk(8'd0, 7'd2, 8'h20, "R8 status");

    // R10 self-clear, R9 re-arm
    wr(8'd1, 7'd31, 8'h40);
    rd_chk(8'd1, 7'd31, 8'h40, "R10 reads 1");
    chk({4'b0, stage_en}, 8'h0F, "R9 stage1 rearmed");
    @(negedge clk);
    rd_chk(8'd1, 7'd31, 8'h00, "R10 reads 0");

    // R9 isolation
    oc_pulse(4'b1001);
    chk({4'b0, stage_en}, 8'h06, "R8 stages 0,3 off");
    wr(8'd1, 7'd31, 8'h80);
    chk({4'b0, stage_en}, 8'h07, "R9 only stage0");
    chk({2'b0, blk_en}, 8'h2A, "R9 blk unchanged");
    wr(8'd1, 7'd32, 8'h40);
    rd_chk(8'd1, 7'd32, 8'h40, "R10 reg32 reads 1");
    chk({4'b0, stage_en}, 8'h0F, "R9 stage3");

    // R11 overcurrent during re-arm
    oc = 4'b0100;
    wr(8'd1, 7'd32, 8'h80);
    oc = '0;
    @(negedge clk);
    chk({4'b0, stage_en}, 8'h0B, "R11 stays off");
    wr(8'd1, 7'd32, 8'h80);
    chk({4'b0, stage_en}, 8'h0F, "R11 rearm later");

    // R12 software reset
    oc_pulse(4'b1000);
    wr(8'd3, 7'd4, 8'h80);
    wr(8'd0, 7'd1, 8'h01);
    chk({7'b0, busy}, 8'h01, "R12 busy");
    chk({2'b0, blk_en}, 8'h00, "R12 blk cleared");
    chk({7'b0, touch_en}, 8'h01, "R12 touch default");
    chk({4'b0, stage_en}, 8'h0F, "R12 latches cleared");
    rd_chk(8'd0, 7'd2, 8'h01, "R12 status");

    // R3 R4 refusals during lockout
    wr(8'd1, 7'd2, 8'hFF);
    chk({2'b0, blk_en}, 8'h00, "R3 blk refused");
    wr(8'd3, 7'd4, 8'h80);
    chk({7'b0, touch_en}, 8'h01, "R3 touch refused");
    wr(8'd1, 7'd5, 8'h80);
    chk({7'b0, synth_en}, 8'h00, "R3 synth refused");
    rd_chk(8'd0, 7'd2, 8'h05, "R3 error set");
    page = 8'd8; we = 1'b1; #1;
    chk({7'b0, coef_we}, 8'h00, "R4 coef refused");
    @(negedge clk); we = 1'b0;

    // R3 sticky after lockout
    repeat (INIT) @(negedge clk);
    rd_chk(8'd0, 7'd2, 8'h04, "R3 error sticky");
    wr(8'd1, 7'd2, 8'h11);
    chk({2'b0, blk_en}, 8'h11, "R5 accepted after lockout");

    summary();
  end
endmodule